// File: doc/BRIEF.md
# Quadrature Mixer and CIC I/Q Decimator

This block turns a stream of signed converter samples into decimated in-phase and quadrature words. Each accepted sample is multiplied by a cosine and a sine local-oscillator value supplied from outside. The two products go through identical two-stage cascaded integrator-comb filters, which low-pass filter and decimate them. The sample rate and the signal frequency are not related by a factor of four, so the LO is a general quadrature pair and not a fixed sign pattern.

Software programs the rate change factor and a matching right shift at run time. A new setting is picked up at the next decimation boundary. The integrator history carries across that change, so no samples are lost, and the first output after the change shows a short transient. Each output word is the filter result shifted right and then cut down to its low bits. A strobe marks every output word.

Top module: `mixcic_iq_dec`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `iq_vld` is 0 and `i_out`/`q_out` are 0. After reset all filter state is zero, the active rate is 100 and the active shift is 14.
- R2: The I product is the full 34-bit signed product of `samp` (16-bit signed) and `lo_cos` (18-bit signed). The Q product is the same with `lo_sin`. Nothing is negated or rounded.
- R3: Each lane has two integrators in cascade, 54 bits wide, that wrap in two's complement. At a decimation boundary the second integrator value goes through two comb stages in cascade. Each comb subtracts the value that stage received at the previous boundary.
- R4: After R accepted samples, `iq_vld` is high for exactly one cycle. That cycle follows the second rising edge after the edge that captured the R-th sample.
- R5: The values on `rate` and `shift` are taken at each decimation boundary and govern the following window. The sample counter restarts at that point, and the integrator and comb state are kept.
- R6: The output word is bits [17:0] of the 54-bit comb result shifted arithmetically right by the shift that was active during that window.
- R7: `i_out` and `q_out` hold their value in every cycle in which `iq_vld` is 0.
- R8: A `rate` of 0 is taken as 1. Rates 1 to 1024 are supported. With rate 1 and shift 16, each output is bits [33:16] of the product.
- R9: A cycle with `samp_vld` low changes neither the sample count nor the filter state, whatever is on `samp` and the LO inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_vld | input | 1 | Sample on `samp` is accepted this cycle |
| samp | input | 16 | Signed sample; narrower converters left-justified |
| lo_cos | input | 18 | Signed cosine LO value |
| lo_sin | input | 18 | Signed sine LO value |
| rate | input | 11 | Decimation factor for the next window (0 means 1) |
| shift | input | 5 | Right shift for the next window, 0 to 20 |
| iq_vld | output | 1 | One-cycle strobe for a new output pair |
| i_out | output | 18 | Decimated in-phase word |
| q_out | output | 18 | Decimated quadrature word |

## Verification
The first run starts with random samples and a pending rate of 37, which separates the reset rate of the first window from the rate picked up at the boundary. Rate 0 with shift 16 makes the filter a pass-through, so the multiply and its sign handling are exposed directly. A full-scale run at rate 1024 drives both integrators through wrap-around and tests that the modular arithmetic still gives the right comb result. Short segments with random rates, random shifts and random idle gaps, plus left-justified 14-bit samples, separate the shift-to-window pairing, idle handling and strobe timing.

// File: rtl/mixcic_pkg.sv
package mixcic_pkg;
    // default geometry of the mixer/decimator
    localparam int DEF_SAMP_W    = 16;
    localparam int DEF_LO_W      = 18;
    localparam int DEF_OUT_W     = 18;
    localparam int DEF_RMAX_LOG  = 10;
    localparam int DEF_STAGES    = 2;
    localparam int DEF_RATE_RST  = 100;
    localparam int DEF_SHIFT_RST = 14;
endpackage

// File: rtl/mixcic_mult.sv
module mixcic_mult #(
    parameter int A_W = 16,
    parameter int B_W = 18,
    localparam int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_in,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           vld,
    output logic [P_W-1:0] p
);
    typedef struct packed {
        logic           vld;
        logic [P_W-1:0] p;
    } mult_st_t;

    mult_st_t s_d, s_q;
    logic signed [P_W-1:0] prod_s;

    assign prod_s = $signed(a) * $signed(b);

    always_comb begin
        s_d     = s_q;
        s_d.vld = vld_in;
        if (vld_in) begin
            s_d.p = prod_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld = s_q.vld;
    assign p   = s_q.p;
endmodule

// File: rtl/mixcic_rate_ctl.sv
module mixcic_rate_ctl #(
    parameter int RATE_W    = 11,
    parameter int SH_W      = 5,
    parameter int RATE_RST  = 100,
    parameter int SHIFT_RST = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [RATE_W-1:0] rate_in,
    input  logic [SH_W-1:0]   shift_in,
    output logic              boundary,
    output logic [SH_W-1:0]   shift_win,
    output logic [RATE_W-1:0] cnt_o,
    output logic [RATE_W-1:0] rate_o
);
    typedef struct packed {
        logic [RATE_W-1:0] cnt;
        logic [RATE_W-1:0] rate;
        logic [SH_W-1:0]   shift;
    } ctl_st_t;

    localparam ctl_st_t CTL_RST = '{
        cnt:   '0,
        rate:  RATE_W'(RATE_RST),
        shift: SH_W'(SHIFT_RST)
    };

    ctl_st_t s_d, s_q;
    logic [RATE_W-1:0] rate_eff;
    logic              last_w;

    assign rate_eff = (rate_in == '0) ? RATE_W'(1) : rate_in;
    assign last_w   = (s_q.cnt == s_q.rate - RATE_W'(1));
    assign boundary = step && last_w;

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (last_w) begin
                s_d.cnt   = '0;
                s_d.rate  = rate_eff;
                s_d.shift = shift_in;
            end else begin
                s_d.cnt = s_q.cnt + RATE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= CTL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign shift_win = s_q.shift;
    assign cnt_o     = s_q.cnt;
    assign rate_o    = s_q.rate;
endmodule

// File: rtl/mixcic_cic.sv
module mixcic_cic #(
    parameter int IN_W   = 34,
    parameter int ACC_W  = 54,
    parameter int STAGES = 2,
    parameter int SH_W   = 5,
    parameter int OUT_W  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IN_W-1:0]  x_in,
    input  logic             boundary,
    input  logic [SH_W-1:0]  shift_win,
    output logic             y_vld,
    output logic [OUT_W-1:0] y
);
    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] integ;
        logic [STAGES-1:0][ACC_W-1:0] comb_prev;
        logic [ACC_W-1:0]             dec;
        logic                         dec_vld;
        logic [SH_W-1:0]              dec_sh;
        logic [OUT_W-1:0]             y;
        logic                         y_vld;
    } cic_st_t;

    cic_st_t s_d, s_q;
    logic [ACC_W-1:0]        acc;
    logic [ACC_W-1:0]        dif;
    logic [ACC_W-1:0]        nxt;
    logic signed [ACC_W-1:0] shd;

    always_comb begin
        s_d         = s_q;
        s_d.dec_vld = 1'b0;
        s_d.y_vld   = 1'b0;
        acc         = {{(ACC_W-IN_W){x_in[IN_W-1]}}, x_in};
        dif         = '0;
        nxt         = '0;
        shd         = '0;

        // integrator cascade, each stage adds the updated value of the one before
        if (step) begin
            for (int i = 0; i < STAGES; i++) begin
                acc          = s_q.integ[i] + acc;
                s_d.integ[i] = acc;
            end
            if (boundary) begin
                s_d.dec     = acc;
                s_d.dec_vld = 1'b1;
                s_d.dec_sh  = shift_win;
            end
        end

        // comb cascade at the decimated rate
        if (s_q.dec_vld) begin
            dif = s_q.dec;
            for (int i = 0; i < STAGES; i++) begin
                nxt              = dif - s_q.comb_prev[i];
                s_d.comb_prev[i] = dif;
                dif              = nxt;
            end
            shd       = $signed(dif) >>> s_q.dec_sh;
            s_d.y     = shd[OUT_W-1:0];
            s_d.y_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign y_vld = s_q.y_vld;
    assign y     = s_q.y;
endmodule

// File: rtl/mixcic_iq_dec.sv
module mixcic_iq_dec
    import mixcic_pkg::*;
#(
    parameter int SAMP_W    = DEF_SAMP_W,
    parameter int LO_W      = DEF_LO_W,
    parameter int OUT_W     = DEF_OUT_W,
    parameter int RMAX_LOG  = DEF_RMAX_LOG,
    parameter int STAGES    = DEF_STAGES,
    parameter int RATE_RST  = DEF_RATE_RST,
    parameter int SHIFT_RST = DEF_SHIFT_RST,
    localparam int PROD_W   = SAMP_W + LO_W,
    localparam int ACC_W    = PROD_W + STAGES * RMAX_LOG,
    localparam int RATE_W   = RMAX_LOG + 1,
    localparam int SH_W     = $clog2(STAGES * RMAX_LOG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_vld,
    input  logic [SAMP_W-1:0] samp,
    input  logic [LO_W-1:0]   lo_cos,
    input  logic [LO_W-1:0]   lo_sin,
    input  logic [RATE_W-1:0] rate,
    input  logic [SH_W-1:0]   shift,
    output logic              iq_vld,
    output logic [OUT_W-1:0]  i_out,
    output logic [OUT_W-1:0]  q_out
);
    localparam int LANES = 2;

    logic [LANES-1:0][LO_W-1:0]   lo_w;
    logic [LANES-1:0]             pv_lane;
    logic [LANES-1:0][PROD_W-1:0] prod_w;
    logic [LANES-1:0]             yv_lane;
    logic [LANES-1:0][OUT_W-1:0]  y_w;
    logic                         pv_w;
    logic                         bnd_w;
    logic [SH_W-1:0]              shw_w;
    logic [RATE_W-1:0]            cnt_w;
    logic [RATE_W-1:0]            ract_w;

    // lane 0 carries the in-phase path, lane 1 the quadrature path
    assign lo_w = {lo_sin, lo_cos};
    assign pv_w = &pv_lane;

    mixcic_rate_ctl #(
        .RATE_W   (RATE_W),
        .SH_W     (SH_W),
        .RATE_RST (RATE_RST),
        .SHIFT_RST(SHIFT_RST)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (pv_w),
        .rate_in  (rate),
        .shift_in (shift),
        .boundary (bnd_w),
        .shift_win(shw_w),
        .cnt_o    (cnt_w),
        .rate_o   (ract_w)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        mixcic_mult #(
            .A_W(SAMP_W),
            .B_W(LO_W)
        ) u_mult (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_in(samp_vld),
            .a     (samp),
            .b     (lo_w[l]),
            .vld   (pv_lane[l]),
            .p     (prod_w[l])
        );

        mixcic_cic #(
            .IN_W  (PROD_W),
            .ACC_W (ACC_W),
            .STAGES(STAGES),
            .SH_W  (SH_W),
            .OUT_W (OUT_W)
        ) u_cic (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (pv_w),
            .x_in     (prod_w[l]),
            .boundary (bnd_w),
            .shift_win(shw_w),
            .y_vld    (yv_lane[l]),
            .y        (y_w[l])
        );
    end

    assign iq_vld = &yv_lane;
    assign i_out  = y_w[0];
    assign q_out  = y_w[1];
endmodule

// File: rtl/mixcic_iq_dec_chk.sv
module mixcic_iq_dec_chk #(
    parameter int SAMP_W = 16,
    parameter int LO_W   = 18,
    parameter int OUT_W  = 18,
    parameter int PROD_W = 34,
    parameter int RATE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_vld,
    input logic [SAMP_W-1:0] samp,
    input logic [LO_W-1:0]   lo_cos,
    input logic              iq_vld,
    input logic [OUT_W-1:0]  i_out,
    input logic [OUT_W-1:0]  q_out,
    input logic              pv,
    input logic [PROD_W-1:0] prod_i,
    input logic              bnd,
    input logic [RATE_W-1:0] cnt,
    input logic [RATE_W-1:0] rate_act
);
    logic signed [PROD_W-1:0] exp_i;
    assign exp_i = $signed(samp) * $signed(lo_cos);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!iq_vld && i_out == '0 && q_out == '0));

    p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pv |-> ($signed(prod_i) == $past(exp_i)));

    p_count_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < rate_act);

    p_strobe_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iq_vld |-> $past(samp_vld, 3));

    p_rate_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(rate_act));

    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !iq_vld |-> ($stable(i_out) && $stable(q_out)));

    p_idle_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pv |=> $stable(cnt));
endmodule

bind mixcic_iq_dec mixcic_iq_dec_chk #(
    .SAMP_W(SAMP_W),
    .LO_W  (LO_W),
    .OUT_W (OUT_W),
    .PROD_W(PROD_W),
    .RATE_W(RATE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp_vld(samp_vld),
    .samp    (samp),
    .lo_cos  (lo_cos),
    .iq_vld  (iq_vld),
    .i_out   (i_out),
    .q_out   (q_out),
    .pv      (pv_w),
    .prod_i  (prod_w[0]),
    .bnd     (bnd_w),
    .cnt     (cnt_w),
    .rate_act(ract_w)
);

// File: tb/sim_mixcic_iq_dec.sv
module sim_mixcic_iq_dec;
    localparam int ACCW = 54;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        samp_vld;
    logic [15:0] samp;
    logic [17:0] lo_cos, lo_sin;
    logic [10:0] rate;
    logic [4:0]  shift;
    logic        iq_vld;
    logic [17:0] i_out, q_out;

    always #4 clk = ~clk;

    mixcic_iq_dec u0 (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp(samp),
        .lo_cos(lo_cos), .lo_sin(lo_sin), .rate(rate), .shift(shift),
        .iq_vld(iq_vld), .i_out(i_out), .q_out(q_out)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit checking = 1'b0;
    bit done     = 1'b0;
    string tag = "R1";

    always @(posedge clk) cyc++;

    typedef struct {
        int          due;
        logic [17:0] ei;
        logic [17:0] eq;
        string       tg;
    } exp_t;
    exp_t exq[$];

    // bench model state: integrators, comb history, window bookkeeping
    longint m_i1[2], m_i2[2], m_c1[2], m_c2[2];
    int m_cnt = 0, m_rate = 100, m_shift = 14;

    function automatic logic [17:0] out_word(longint c2, int sh);
        longint w;
        w = (c2 <<< (64 - ACCW)) >>> (64 - ACCW);
        w = w >>> sh;
        return w[17:0];
    endfunction

    task automatic model_step(logic [15:0] s, logic [17:0] c, logic [17:0] sn);
        longint sv, lo, p, d1, d2;
        logic [17:0] res[2];
        sv = $signed(s);
        for (int l = 0; l < 2; l++) begin
            lo = (l == 0) ? longint'($signed(c)) : longint'($signed(sn));
            p = sv * lo;
            m_i1[l] = m_i1[l] + p;
            m_i2[l] = m_i2[l] + m_i1[l];
        end
        m_cnt++;
        if (m_cnt == m_rate) begin
            for (int l = 0; l < 2; l++) begin
                d1 = m_i2[l] - m_c1[l];
                m_c1[l] = m_i2[l];
                d2 = d1 - m_c2[l];
                m_c2[l] = d1;
                res[l] = out_word(d2, m_shift);
            end
            exq.push_back('{due: cyc + 3, ei: res[0], eq: res[1], tg: tag});
            m_rate  = (rate == 0) ? 1 : int'(rate);
            m_shift = int'(shift);
            m_cnt   = 0;
        end
    endtask

    task automatic send(logic [15:0] s, logic [17:0] c, logic [17:0] sn);
        @(negedge clk);
        samp_vld = 1'b1;
        samp = s; lo_cos = c; lo_sin = sn;
        model_step(s, c, sn);
    endtask

    task automatic send_rand();
        send(16'($urandom), 18'($urandom), 18'($urandom));
    endtask

    // idle cycles carry garbage on the data inputs (R9)
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            samp_vld = 1'b0;
            samp = 16'($urandom); lo_cos = 18'($urandom); lo_sin = 18'($urandom);
        end
    endtask

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    logic [17:0] last_i = '0, last_q = '0;

    always @(negedge clk) begin
        if (checking) begin
            if (exq.size() > 0 && exq[0].due == cyc) begin
                check(iq_vld == 1'b1, "R4", "strobe missing", iq_vld, 1);
                check(i_out == exq[0].ei, exq[0].tg, "i_out", i_out, exq[0].ei);
                check(q_out == exq[0].eq, exq[0].tg, "q_out", q_out, exq[0].eq);
                void'(exq.pop_front());
            end else if (iq_vld) begin
                check(1'b0, "R4", "unexpected strobe", 1, 0);
            end else begin
                // R7: outputs hold while no strobe
                check(i_out == last_i && q_out == last_q, "R7", "hold",
                      {i_out, q_out}, {last_i, last_q});
            end
            last_i = i_out;
            last_q = q_out;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < 2; l++) begin
            m_i1[l] = 0; m_i2[l] = 0; m_c1[l] = 0; m_c2[l] = 0;
        end
        rst_n = 1'b0; samp_vld = 1'b0; samp = '0; lo_cos = '0; lo_sin = '0;
        rate = 11'd37; shift = 5'd11;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!iq_vld && i_out == 0 && q_out == 0, "R1", "in reset", {iq_vld, i_out, q_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!iq_vld && i_out == 0 && q_out == 0, "R1", "after release", {iq_vld, i_out, q_out}, 0);
        checking = 1'b1;

        // R1 R5: first window uses reset rate 100, later windows take 37
        tag = "R1 R5 reset rate then loaded rate";
        for (int k = 0; k < 250; k++) send_rand();
        idle(6);

        // R2 R8: rate 0 acts as 1, shift 16 exposes product bits [33:16]
        rate = 11'd0; shift = 5'd16;
        tag = "R2 R8 pass-through";
        for (int k = 0; k < 40; k++) send_rand();
        idle(6);

        // R3 R8: full-scale inputs at rate 1024, integrators wrap
        rate = 11'd1024; shift = 5'd20;
        tag = "R3 R8 full-scale wrap";
        for (int k = 0; k < 2100; k++) send(16'h8000, 18'h20000, 18'h1FFFF);
        idle(6);

        // R6 R9: random rate and shift, random idle gaps
        tag = "R6 R9 random rate shift gaps";
        for (int seg = 0; seg < 10; seg++) begin
            rate  = 11'(1 + ($urandom % 40));
            shift = 5'($urandom % 21);
            for (int k = 0; k < 150; k++) begin
                if (($urandom % 10) < 3) idle(1 + ($urandom % 4));
                send_rand();
            end
            idle(6);
        end

        // R3: left-justified 14-bit samples
        rate = 11'd100; shift = 5'd14;
        tag = "R3 left-justified 14-bit";
        for (int k = 0; k < 400; k++)
            send({14'($urandom), 2'b00}, 18'($urandom), 18'($urandom));
        idle(10);

        check(exq.size() == 0, "R4", "outputs still pending", exq.size(), 0);
        finish_run();
    end
endmodule